// File: doc/BRIEF.md
# Two-Wire Quad Digital Potentiometer Register Slave

This block is the control side of a four-channel digital potentiometer. It sits on a two-wire serial bus as a slave and runs on a faster system clock. Both bus lines are synchronised and their edges detected in that clock domain. It holds one volatile wiper register per channel, a bank of data registers arranged in pages of four (one entry per channel), and a volatile status byte. The four wiper values leave the block as 8-bit tap positions. Those tap positions drive the resistor switch decoders elsewhere in the chip.

A master selects the slave with an address byte. The master then sends a pointer byte naming the register kind, the page and the channel, followed by zero or more data bytes. To read, the master issues a repeated START and the read address. The channel index in the pointer advances after every byte, wrapping inside the page. Any access to a data register also loads the value into that channel's wiper. A data register write with write enable high starts a timed busy window at the STOP. While the window runs the slave ignores its address, so the master polls until it is acknowledged again.

Top module: `dpot_top`

## Requirements
- R1: The address byte is, MSB first, a 4-bit device code (parameter DEV_ID, default 4'b0101), the 3 bits of dev_addr_i and a R/W bit (1 = read). The slave acknowledges only when the 7 upper bits match and it is not busy. Otherwise it leaves SDA released until the next START.
- R2: After every byte it receives while selected, the slave holds SDA low for the ninth clock. It changes SDA only while SCL is low.
- R3: The pointer byte (first byte after a write address) is decoded as follows: bits [7:6] give the kind (00 wiper, 01 data register, 10 status, 11 none, reading as 0); bits [5:4] give the page; bits [1:0] give the channel.
- R4: A byte written to a wiper register appears on wipers_o, with channel i in bits [8i+7:8i]. The slave acknowledges its address straight after the STOP.
- R5: Successive data bytes go to successive channels, wrapping from 3 to 0 while kind and page stay fixed, so all four wipers can be loaded in one transfer.
- R6: A random read returns the addressed register. Each master ACK makes the slave send the next channel's register.
- R7: After a master NACK, the slave releases SDA and sends nothing until a START.
- R8: A data register write with wp_i high stores the byte and copies it to the channel's wiper. The following STOP starts a busy window of BUSY_CYCLES clocks, during which address bytes are not acknowledged.
- R9: A data register write with wp_i low leaves the data register unchanged, still loads the wiper, and starts no busy window.
- R10: Reading a data register loads its value into that channel's wiper.
- R11: After reset, all wipers, data registers and status are zero and SDA is released.
- R12: The status byte is volatile and reads back what was last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| dev_addr_i | input | 3 | Low three bits of the slave address |
| wp_i | input | 1 | 1 enables data register writes |
| wipers_o | output | 32 | Four 8-bit wiper tap positions |

## Verification
The bench goes after the channel wrap in a page write: a slave that carried into the page field would load the wrong wipers. It also covers the repeated START between the write and read phases; a slave that lost the pointer there would return the wrong register. Polling after a protected write must see at least one unacknowledged address before an acknowledged one; an early or absent busy window shows up as a first-poll ACK. The tests with write enable low, and the data register read that overwrites a wiper, catch a slave that separates the wiper copy from the store.

// File: rtl/dpot_pkg.sv
package dpot_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_RX, S_RX_ACK, S_TX, S_TX_ACK
  } link_state_e;

  localparam logic [1:0] KIND_WIPER  = 2'b00;
  localparam logic [1:0] KIND_DREG   = 2'b01;
  localparam logic [1:0] KIND_STATUS = 2'b10;
endpackage

// File: rtl/dpot_line_sync.sv
module dpot_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 3'b111;
      sda_q <= 3'b111;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end
  end

  assign scl_o      = scl_q[1];
  assign sda_o      = sda_q[1];
  assign scl_rise_o = scl_q[1] & ~scl_q[2];
  assign scl_fall_o = ~scl_q[1] & scl_q[2];
  assign start_o    = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_o     = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/dpot_link.sv
module dpot_link
  import dpot_pkg::*;
#(
  parameter logic [3:0] DEV_ID = 4'b0101
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [2:0] dev_addr_i,
  input  logic       busy_i,
  input  logic [7:0] rd_data_i,
  output logic       sda_oe_o,
  output logic       ptr_we_o,
  output logic       wr_en_o,
  output logic [7:0] byte_o,
  output logic       rd_load_o,
  output logic       addr_ack_o
);
  link_state_e state_q;
  logic [7:0]  sh_q;
  logic [3:0]  cnt_q;
  logic        rw_q, first_q, mack_q;

  assign byte_o     = sh_q;
  assign addr_ack_o = (state_q == S_ADDR_ACK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      sh_q      <= '0;
      cnt_q     <= '0;
      rw_q      <= 1'b0;
      first_q   <= 1'b0;
      mack_q    <= 1'b0;
      sda_oe_o  <= 1'b0;
      ptr_we_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      rd_load_o <= 1'b0;
    end else begin
      ptr_we_o  <= 1'b0;
      wr_en_o   <= 1'b0;
      rd_load_o <= 1'b0;
      if (start_i) begin
        state_q  <= S_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state_q  <= S_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state_q)
          S_IDLE: ;
          S_ADDR, S_RX: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (state_q == S_ADDR) begin
                if (sh_q[7:1] == {DEV_ID, dev_addr_i} && !busy_i) begin
                  sda_oe_o <= 1'b1;
                  rw_q     <= sh_q[0];
                  state_q  <= S_ADDR_ACK;
                end else begin
                  state_q  <= S_IDLE;
                end
              end else begin
                sda_oe_o <= 1'b1;
                state_q  <= S_RX_ACK;
                first_q  <= 1'b0;
                if (first_q) ptr_we_o <= 1'b1;
                else         wr_en_o  <= 1'b1;
              end
            end
          end
          S_ADDR_ACK, S_RX_ACK: begin
            if (scl_fall_i) begin
              if (state_q == S_ADDR_ACK && rw_q) begin
                sh_q      <= rd_data_i;
                sda_oe_o  <= ~rd_data_i[7];
                rd_load_o <= 1'b1;
                cnt_q     <= 4'd1;
                state_q   <= S_TX;
              end else begin
                if (state_q == S_ADDR_ACK) first_q <= 1'b1;
                sda_oe_o <= 1'b0;
                cnt_q    <= '0;
                state_q  <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                sda_oe_o <= 1'b0;
                state_q  <= S_TX_ACK;
              end else begin
                sda_oe_o <= ~sh_q[6];
                sh_q     <= {sh_q[6:0], 1'b0};
                cnt_q    <= cnt_q + 4'd1;
              end
            end
          end
          S_TX_ACK: begin
            if (scl_rise_i) begin
              mack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (mack_q) begin
                sh_q      <= rd_data_i;
                sda_oe_o  <= ~rd_data_i[7];
                rd_load_o <= 1'b1;
                cnt_q     <= 4'd1;
                state_q   <= S_TX;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          default: state_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpot_regs.sv
module dpot_regs
  import dpot_pkg::*;
#(
  parameter int NUM_POTS  = 4,
  parameter int NUM_PAGES = 4,
  parameter int DW        = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   ptr_we_i,
  input  logic                   wr_en_i,
  input  logic                   rd_load_i,
  input  logic [7:0]             byte_i,
  input  logic                   wp_i,
  output logic [7:0]             rd_data_o,
  output logic                   nv_wr_o,
  output logic [7:0]             ptr_o,
  output logic [NUM_POTS*DW-1:0] wipers_o
);
  localparam int POT_W  = $clog2(NUM_POTS);
  localparam int PAGE_W = $clog2(NUM_PAGES);
  localparam int NDR    = NUM_POTS * NUM_PAGES;

  logic [7:0]                ptr_q;
  logic [DW-1:0]             wiper_q [NUM_POTS];
  logic [DW-1:0]             dr_q    [NDR];
  logic [DW-1:0]             status_q;
  logic [1:0]                kind;
  logic [POT_W-1:0]          pot;
  logic [PAGE_W+POT_W-1:0]   dr_idx;

  assign kind   = ptr_q[7:6];
  assign pot    = ptr_q[POT_W-1:0];
  assign dr_idx = {ptr_q[4 +: PAGE_W], pot};
  assign ptr_o  = ptr_q;
  assign nv_wr_o = wr_en_i && kind == KIND_DREG && wp_i;

  always_comb begin
    unique case (kind)
      KIND_WIPER:  rd_data_o = 8'(wiper_q[pot]);
      KIND_DREG:   rd_data_o = 8'(dr_q[dr_idx]);
      KIND_STATUS: rd_data_o = 8'(status_q);
      default:     rd_data_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q    <= '0;
      status_q <= '0;
      for (int i = 0; i < NUM_POTS; i++) wiper_q[i] <= '0;
      for (int i = 0; i < NDR; i++)      dr_q[i]    <= '0;
    end else if (ptr_we_i) begin
      ptr_q <= byte_i;
    end else if (wr_en_i) begin
      unique case (kind)
        KIND_WIPER:  wiper_q[pot] <= DW'(byte_i);
        KIND_DREG: begin
          wiper_q[pot] <= DW'(byte_i);
          if (wp_i) dr_q[dr_idx] <= DW'(byte_i);
        end
        KIND_STATUS: status_q <= DW'(byte_i);
        default: ;
      endcase
      ptr_q[POT_W-1:0] <= pot + 1'b1;
    end else if (rd_load_i) begin
      if (kind == KIND_DREG) wiper_q[pot] <= dr_q[dr_idx];
      ptr_q[POT_W-1:0] <= pot + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_POTS; g++) begin : g_wout
    assign wipers_o[g*DW +: DW] = wiper_q[g];
  end
endmodule

// File: rtl/dpot_busy.sv
module dpot_busy #(
  parameter int BUSY_CYCLES = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nv_wr_i,
  input  logic start_i,
  input  logic stop_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (start_i)      pend_q <= 1'b0;
      else if (nv_wr_i) pend_q <= 1'b1;
      else if (stop_i)  pend_q <= 1'b0;

      if (stop_i && pend_q) cnt_q <= CW'(BUSY_CYCLES);
      else if (busy_o)      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/dpot_top.sv
module dpot_top #(
  parameter logic [3:0] DEV_ID      = 4'b0101,
  parameter int         NUM_PAGES   = 4,
  parameter int         BUSY_CYCLES = 500000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [2:0]  dev_addr_i,
  input  logic        wp_i,
  output logic [31:0] wipers_o
);
  logic       scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic       busy, ptr_we, wr_en, rd_load, nv_wr, addr_ack;
  logic [7:0] rx_byte, rd_data, ptr;

  dpot_line_sync u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_evt), .stop_o(stop_evt)
  );

  dpot_link #(.DEV_ID(DEV_ID)) u_link (
    .clk_i, .rst_ni, .sda_i(sda_s), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_evt), .stop_i(stop_evt), .dev_addr_i, .busy_i(busy),
    .rd_data_i(rd_data), .sda_oe_o, .ptr_we_o(ptr_we), .wr_en_o(wr_en),
    .byte_o(rx_byte), .rd_load_o(rd_load), .addr_ack_o(addr_ack)
  );

  dpot_regs #(.NUM_POTS(4), .NUM_PAGES(NUM_PAGES), .DW(8)) u_regs (
    .clk_i, .rst_ni, .ptr_we_i(ptr_we), .wr_en_i(wr_en), .rd_load_i(rd_load),
    .byte_i(rx_byte), .wp_i, .rd_data_o(rd_data), .nv_wr_o(nv_wr),
    .ptr_o(ptr), .wipers_o
  );

  dpot_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk_i, .rst_ni, .nv_wr_i(nv_wr), .start_i(start_evt), .stop_i(stop_evt),
    .busy_o(busy)
  );
endmodule

// File: rtl/dpot_chk.sv
module dpot_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        scl_s,
  input logic        start_evt,
  input logic        stop_evt,
  input logic        sda_oe_o,
  input logic        busy,
  input logic        addr_ack,
  input logic        wr_en,
  input logic        rd_load,
  input logic [7:0]  ptr,
  input logic [31:0] wipers_o
);
  p_sda_low_only_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_oe_o) && !start_evt && !stop_evt) |-> !scl_s);

  p_no_ack_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !addr_ack);

  p_busy_from_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(stop_evt));

  p_wiper_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en || rd_load) |=> $stable(wipers_o));

  p_page_fixed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |=> $stable(ptr[7:2]));
endmodule

bind dpot_top dpot_chk u_chk (
  .clk_i, .rst_ni, .scl_s, .start_evt, .stop_evt, .sda_oe_o,
  .busy, .addr_ack, .wr_en, .rd_load, .ptr, .wipers_o
);

// File: tb/tb_dpot_top.sv
module tb_dpot_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  Q = 8;
  localparam int  BUSY = 2000;
  localparam logic [7:0] AW = 8'h56, AR = 8'h57;

  logic clk = 0, rst_n = 0, m_scl = 1, m_sda = 1, wp = 0;
  logic sda_oe, sda_bus;
  logic [31:0] wipers;
  int checks = 0, fails = 0;
  logic [7:0] exp_w [4];

  assign sda_bus = m_sda & ~sda_oe;
  always #(CLK_PERIOD/2) clk = ~clk;

  dpot_top #(.DEV_ID(4'b0101), .NUM_PAGES(4), .BUSY_CYCLES(BUSY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .dev_addr_i(3'b011), .wp_i(wp), .wipers_o(wipers)
  );

  // {pointer, data}
  localparam logic [15:0] VEC [6] = '{
    16'h003C, 16'h03C3, 16'h805A, 16'h01FF, 16'h0200, 16'h80A5
  };

  task automatic wq(int n); repeat (n * Q) @(negedge clk); endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic i2c_start();
    m_sda = 1; wq(1); m_scl = 1; wq(2); m_sda = 0; wq(2); m_scl = 0; wq(1);
  endtask

  task automatic i2c_stop();
    m_sda = 0; wq(1); m_scl = 1; wq(2); m_sda = 1; wq(2);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(1); m_scl = 1; wq(2); m_scl = 0; wq(1);
    end
    m_sda = 1; wq(1); m_scl = 1; wq(1); ack = ~sda_bus; wq(1); m_scl = 0; wq(1);
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] b);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wq(1); m_scl = 1; wq(1); b[i] = sda_bus; wq(1); m_scl = 0;
    end
    wq(1); m_sda = ~mack; wq(1); m_scl = 1; wq(2); m_scl = 0; wq(1); m_sda = 1;
  endtask

  task automatic wr1(input logic [7:0] p, input logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i2c_start(); wbyte(AW, a0); wbyte(p, a1); wbyte(d, a2); i2c_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic rd1(input logic [7:0] p, output logic [7:0] d, output logic ok);
    logic a0, a1, a2;
    i2c_start(); wbyte(AW, a0); wbyte(p, a1);
    i2c_start(); wbyte(AR, a2); rbyte(1'b0, d); i2c_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    logic ok, a;
    logic [7:0] d;
    int polls;
    for (int i = 0; i < 4; i++) exp_w[i] = 8'h00;
    repeat (5) @(negedge clk);
    // R11 reset state
    chk("R11 wipers", wipers, 32'h0);
    chk("R11 sda", {31'h0, sda_oe}, 32'h0);
    rst_n = 1; wq(2);
    rd1(8'h80, d, ok);
    chk("R11 status", {24'h0, d}, 32'h0);

    // R1 foreign address ignored
    i2c_start(); wbyte(8'h58, a); i2c_stop();
    chk("R1 wrong addr nack", {31'h0, a}, 32'h0);
    i2c_start(); wbyte(AW, a); i2c_stop();
    chk("R1 own addr ack", {31'h0, a}, 32'h1);

    // R2 R3 R4 R6 R12 vector walk
    for (int v = 0; v < 6; v++) begin
      wr1(VEC[v][15:8], VEC[v][7:0], ok);
      chk("R2 byte acks", {31'h0, ok}, 32'h1);
      if (VEC[v][15:14] == 2'b00) begin
        exp_w[VEC[v][9:8]] = VEC[v][7:0];
        chk("R4 wiper out", wipers, {exp_w[3], exp_w[2], exp_w[1], exp_w[0]});
      end
      rd1(VEC[v][15:8], d, ok);
      chk("R4 ready after stop", {31'h0, ok}, 32'h1);
      chk("R6 R12 readback", {24'h0, d}, {24'h0, VEC[v][7:0]});
    end

    // R5 page write wrapping from channel 2
    i2c_start(); wbyte(AW, a); ok = a;
    wbyte(8'h02, a); ok &= a;
    wbyte(8'h11, a); ok &= a; wbyte(8'h22, a); ok &= a;
    wbyte(8'h33, a); ok &= a; wbyte(8'h44, a); ok &= a;
    i2c_stop();
    chk("R2 page acks", {31'h0, ok}, 32'h1);
    chk("R5 page wrap", wipers, 32'h22114433);

    // R6 sequential read, R7 nack release
    i2c_start(); wbyte(AW, a); wbyte(8'h00, a);
    i2c_start(); wbyte(AR, a);
    rbyte(1'b1, d); chk("R6 seq 0", {24'h0, d}, 32'h33);
    rbyte(1'b1, d); chk("R6 seq 1", {24'h0, d}, 32'h44);
    rbyte(1'b1, d); chk("R6 seq 2", {24'h0, d}, 32'h11);
    rbyte(1'b0, d); chk("R6 seq 3", {24'h0, d}, 32'h22);
    rbyte(1'b0, d); chk("R7 released after nack", {24'h0, d}, 32'hFF);
    i2c_stop();

    // R8 protected data register write and busy polling
    wp = 1;
    wr1(8'h51, 8'hA5, ok);
    chk("R8 dreg write ack", {31'h0, ok}, 32'h1);
    chk("R8 wiper copy", {24'h0, wipers[15:8]}, 32'hA5);
    polls = 0; a = 0;
    while (!a && polls < 40) begin
      i2c_start(); wbyte(AW, a); i2c_stop(); polls++;
    end
    chk("R8 first poll nack", {31'h0, polls > 1}, 32'h1);
    chk("R8 ack returns", {31'h0, a}, 32'h1);
    rd1(8'h51, d, ok);
    chk("R8 dreg stored", {24'h0, d}, 32'hA5);

    // R9 unprotected write, R10 read copies to wiper
    wp = 0;
    wr1(8'h51, 8'h77, ok);
    chk("R9 wiper loaded", {24'h0, wipers[15:8]}, 32'h77);
    i2c_start(); wbyte(AW, a); i2c_stop();
    chk("R9 no busy", {31'h0, a}, 32'h1);
    rd1(8'h51, d, ok);
    chk("R9 dreg unchanged", {24'h0, d}, 32'hA5);
    chk("R10 read loads wiper", {24'h0, wipers[15:8]}, 32'hA5);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule